// File: doc/BRIEF.md
# Frame-Aligned Payload Deserializer

This block turns a serial receive payload into parallel words for a transparent receive path. In this path HDLC processing is bypassed. Word boundaries come from the frame alignment reported by an external frame synchronizer, not from flag detection. Every payload bit reaches the output unchanged, and no stuffed zero is removed. The block watches its position inside the current frame, so that overhead bits never reach the output.

Two framing formats are supported:

- **E3 framing:** a frame is 1536 bits. The first 16 bits are overhead, and 190 payload bytes follow.
- **DS3 framing:** a frame is 4760 bits. The first bit of every 85-bit block is overhead, which leaves 588 payload bytes per frame.

The block can emit 8-bit bytes, or 4-bit nibbles on the low bus lines. Nibble output is available with DS3 framing only. A single-cycle strobe marks each new word, and the word stays on the bus until the next strobe.

Top module: `payload_deser`

## Requirements
- R1: While reset is held, and after it is released, the data bus reads 0x00 and the strobe is low until the first word is completed.
- R2: No strobe appears before the first frame pulse, which is `frameSync` high in a cycle where `bitEn` is high.
- R3: With `e3Mode`=1, frame positions 0..15 are skipped and exactly 190 bytes are produced per 1536-bit frame. The frame pulse marks position 0.
- R4: With `e3Mode`=0, every position p of a 4760-bit frame with p mod 85 = 0 is skipped, and exactly 588 bytes are produced per frame.
- R5: In byte mode, the first payload bit of each byte appears on `dataOut[7]` and the last on `dataOut[0]`.
- R6: With `nibbleMode`=1 and `e3Mode`=0, a strobe follows every 4 payload bits. The first bit of the group is on `dataOut[3]`, the last is on `dataOut[0]`, and `dataOut[7:4]` is 0.
- R7: With `e3Mode`=1, `nibbleMode` has no effect and whole bytes are produced.
- R8: No bit is deleted. A 0 that follows five 1s is delivered like any other payload bit.
- R9: Without a new frame pulse, the position wraps to 0 after the last position of the frame, and the next frame is deserialized the same way.
- R10: A frame pulse that arrives in the middle of a word discards the partial word and restarts the word from the next payload bit.
- R11: The strobe is high for one cycle only, one clock after the bit that completes a word. `dataOut` changes only together with a strobe.
- R12: A cycle with `bitEn` low advances nothing, and it is never followed by a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bitEn | input | 1 | Marks a cycle carrying a valid received bit |
| serIn | input | 1 | Received serial bit |
| frameSync | input | 1 | Frame alignment pulse, qualified by `bitEn`, on frame position 0 |
| e3Mode | input | 1 | 1 selects E3 framing, 0 selects DS3 framing |
| nibbleMode | input | 1 | 1 selects 4-bit output, honoured under DS3 framing only |
| dataOut | output | 8 | Deserialized word, held between strobes |
| dataStb | output | 1 | One-cycle pulse when `dataOut` carries a new word |

## Verification
The assertions assume three things about the inputs:

- `e3Mode` and `nibbleMode` stay still while a frame is being received.
- A mode change is followed by a fresh frame pulse.
- `frameSync` only ever marks position 0 of a frame.

The stimulus keeps to these rules. It changes modes only while `bitEn` is low and every expected word has been delivered, and it then starts with a frame pulse. The one deliberate misplaced pulse comes a few bits into a frame, to test R10, and the new frame is counted from that point. Idle cycles are inserted at random between bits, so the strobe timing is tested with irregular bit spacing.

// File: rtl/payload_deser_pkg.sv
package payload_deser_pkg;
  localparam int BUS_W          = 8;
  localparam int NIB_W          = 4;
  localparam int E3_FRAME_BITS  = 1536;
  localparam int E3_OH_BITS     = 16;
  localparam int DS3_FRAME_BITS = 4760;
  localparam int DS3_BLOCK_BITS = 85;
  localparam int POS_W = $clog2(DS3_FRAME_BITS);
  localparam int BLK_W = $clog2(DS3_BLOCK_BITS);
  localparam int CNT_W = $clog2(BUS_W);

  typedef struct packed {
    logic shift;   // accept serIn into the assembly register
    logic load;    // this bit completes a word
    logic nibble;  // effective word width is NIB_W
  } deser_ctrl_t;
endpackage

// File: rtl/payload_deser_ctrl.sv
module payload_deser_ctrl
  import payload_deser_pkg::*;
#(
  parameter int E3_FRAME  = E3_FRAME_BITS,
  parameter int E3_OH     = E3_OH_BITS,
  parameter int DS3_FRAME = DS3_FRAME_BITS,
  parameter int DS3_BLOCK = DS3_BLOCK_BITS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        frameSync,
  input  logic        e3Mode,
  input  logic        nibbleMode,
  output deser_ctrl_t ctrl
);
  localparam logic [POS_W-1:0] E3_LAST  = POS_W'(E3_FRAME - 1);
  localparam logic [POS_W-1:0] DS3_LAST = POS_W'(DS3_FRAME - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(DS3_BLOCK - 1);

  logic [POS_W-1:0] posQ, curPos, lastPos;
  logic [BLK_W-1:0] blkQ, curBlk;
  logic [CNT_W-1:0] cntQ, lastCnt;
  logic lockedQ, locked, sync, isOh, effNib, take;

  always_comb begin
    sync    = frameSync & bitEn;
    effNib  = nibbleMode & ~e3Mode;
    lastCnt = effNib ? CNT_W'(NIB_W - 1) : CNT_W'(BUS_W - 1);
    lastPos = e3Mode ? E3_LAST : DS3_LAST;
    curPos  = sync ? '0 : posQ;
    curBlk  = sync ? '0 : blkQ;
    isOh    = e3Mode ? (curPos < POS_W'(E3_OH)) : (curBlk == '0);
    locked  = lockedQ | sync;
    take    = bitEn & locked & ~isOh;
    ctrl.shift  = take;
    ctrl.load   = take & (cntQ == lastCnt);
    ctrl.nibble = effNib;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ    <= '0;
      blkQ    <= '0;
      cntQ    <= '0;
      lockedQ <= 1'b0;
    end else if (bitEn) begin
      posQ    <= (curPos == lastPos) ? '0 : curPos + 1'b1;
      blkQ    <= (curBlk == BLK_LAST) ? '0 : curBlk + 1'b1;
      lockedQ <= locked;
      if (sync)
        cntQ <= '0;
      else if (take)
        cntQ <= (cntQ == lastCnt) ? '0 : cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/payload_deser_dp.sv
module payload_deser_dp
  import payload_deser_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  deser_ctrl_t      ctrl,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataStb
);
  logic [BUS_W-2:0] shQ;
  logic [BUS_W-1:0] assembled, word;

  always_comb begin
    assembled = {shQ, serIn};
    word = ctrl.nibble ? BUS_W'(assembled[NIB_W-1:0]) : assembled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ     <= '0;
      dataOut <= '0;
      dataStb <= 1'b0;
    end else begin
      dataStb <= ctrl.load;
      if (ctrl.shift) shQ <= assembled[BUS_W-2:0];
      if (ctrl.load)  dataOut <= word;
    end
  end
endmodule

// File: rtl/payload_deser.sv
module payload_deser
  import payload_deser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       serIn,
  input  logic       frameSync,
  input  logic       e3Mode,
  input  logic       nibbleMode,
  output logic [7:0] dataOut,
  output logic       dataStb
);
  deser_ctrl_t ctrl;

  payload_deser_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .e3Mode(e3Mode), .nibbleMode(nibbleMode), .ctrl(ctrl)
  );

  payload_deser_dp dp_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .ctrl(ctrl),
    .dataOut(dataOut), .dataStb(dataStb)
  );
endmodule

// File: rtl/payload_deser_checker.sv
module payload_deser_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       frameSync,
  input logic       e3Mode,
  input logic       nibbleMode,
  input logic [7:0] dataOut,
  input logic       dataStb
);
  logic seenSync;
  always_ff @(posedge clk) begin
    if (!rstN) seenSync <= 1'b0;
    else if (frameSync && bitEn) seenSync <= 1'b1;
  end

  assert_no_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    !seenSync |-> !dataStb);

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |=> !dataStb);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !dataStb |-> $stable(dataOut));

  assert_nibble_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && nibbleMode && !e3Mode) |-> (dataOut[7:4] == 4'h0));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> !dataStb);
endmodule

bind payload_deser payload_deser_checker chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
  .e3Mode(e3Mode), .nibbleMode(nibbleMode), .dataOut(dataOut), .dataStb(dataStb)
);

// File: tb/payload_deser_tb_top.sv
module payload_deser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, serIn = 1'b0, frameSync = 1'b0;
  logic e3Mode = 1'b1, nibbleMode = 1'b0;
  logic [7:0] dataOut;
  logic       dataStb;

  payload_deser dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .serIn(serIn), .frameSync(frameSync),
    .e3Mode(e3Mode), .nibbleMode(nibbleMode), .dataOut(dataOut), .dataStb(dataStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] expQ[$];
  int nChecks = 0, nFails = 0;
  int strobeCnt = 0, holdErr = 0;
  string curReq = "R1";
  logic [7:0] lastOut = 8'h00;

  // reference model state
  logic [7:0] acc = 8'h00;
  int accCnt = 0, bitPos = 0;
  bit mLocked = 0;

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // monitor: pops and compares as words come out
  always @(negedge clk) begin
    if (rstN) begin
      if (dataStb) begin
        strobeCnt++;
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL %s: unexpected word got 0x%02h expected none", curReq, dataOut);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (dataOut !== e) begin
            nFails++;
            $display("FAIL %s: word got 0x%02h expected 0x%02h", curReq, dataOut, e);
          end
        end
      end else if (dataOut !== lastOut) begin
        holdErr++;
      end
      lastOut = dataOut;
    end
  end

  task automatic driveBit(input logic b, input logic sync);
    int w, flen;
    bit oh;
    if ($urandom_range(3) == 0) begin
      @(negedge clk);
      bitEn = 1'b0; frameSync = 1'b0;
    end
    @(negedge clk);
    bitEn = 1'b1; serIn = b; frameSync = sync;
    w    = (nibbleMode && !e3Mode) ? 4 : 8;
    flen = e3Mode ? 1536 : 4760;
    if (sync) begin bitPos = 0; accCnt = 0; mLocked = 1; end
    oh = e3Mode ? (bitPos < 16) : (bitPos % 85 == 0);
    if (mLocked && !oh) begin
      acc = {acc[6:0], b};
      accCnt++;
      if (accCnt == w) begin
        expQ.push_back(w == 4 ? {4'h0, acc[3:0]} : acc);
        accCnt = 0;
      end
    end
    bitPos = (bitPos + 1) % flen;
  endtask

  // pattern 0: random, 1: repeating 111110
  task automatic sendBits(input int n, input bit syncFirst, input int pattern);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = (pattern == 1) ? ((i % 6) != 5) : 1'($urandom_range(1));
      driveBit(b, syncFirst && (i == 0));
    end
  endtask

  task automatic drain();
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    repeat (4) @(negedge clk);
    check({curReq, " queue empty"}, expQ.size(), 0);
  endtask

  task automatic runFrame(input string req, input bit e3, input bit nib, input bit sync,
                          input int pattern, input int expWords);
    int base;
    curReq = req;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    e3Mode = e3; nibbleMode = nib;
    base = strobeCnt;
    sendBits(e3 ? 1536 : 4760, sync, pattern);
    drain();
    check({req, " word count"}, strobeCnt - base, expWords);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 dataOut in reset", dataOut, 0);
    check("R1 dataStb in reset", dataStb, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 dataOut after reset", dataOut, 0);

    // R2: bits before any frame pulse
    curReq = "R2";
    base = strobeCnt;
    sendBits(200, 1'b0, 0);
    drain();
    check("R2 no words before pulse", strobeCnt - base, 0);

    runFrame("R3 R5 E3 byte", 1'b1, 1'b0, 1'b1, 0, 190);
    runFrame("R9 E3 wrap", 1'b1, 1'b0, 1'b0, 0, 190);
    runFrame("R8 no deletion", 1'b1, 1'b0, 1'b1, 1, 190);
    runFrame("R4 DS3 byte", 1'b0, 1'b0, 1'b1, 0, 588);
    runFrame("R6 DS3 nibble", 1'b0, 1'b1, 1'b1, 0, 1176);
    runFrame("R7 E3 ignores nibble", 1'b1, 1'b1, 1'b1, 0, 190);

    // R10: pulse mid-byte, 16 overhead + 13 payload bits, then a new pulse
    curReq = "R10";
    @(negedge clk);
    bitEn = 1'b0; e3Mode = 1'b1; nibbleMode = 1'b0;
    base = strobeCnt;
    sendBits(29, 1'b1, 0);
    // R12: long idle with a partial byte pending
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    repeat (30) @(negedge clk);
    check("R12 no word while idle", strobeCnt - base, 1);
    sendBits(1536, 1'b1, 0);
    drain();
    check("R10 word count", strobeCnt - base, 191);

    check("R11 data held between strobes", holdErr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule